// File: doc/BRIEF.md
# Hit-Driven Data Tile Builder

This block serves one group of sixteen wire channels in a self-triggering read-out chain. Every valid sample frame (sixteen 16-bit channel samples plus one hit flag per channel) is written into a circular ring that is never paused. A 32-bit absolute time tag counts valid frames, and frame `t` is stored at ring address `t mod RING_DEPTH`. The host reads any ring address through a registered read port.

The block decides which stretches of the stream are worth keeping and records each one as a fragment descriptor: the mode code, the time tag of the first sample and the sample count. It has three capture modes. In full-drift capture, an external trigger opens a long fixed window. In gated capture, a hit anywhere in the group opens a tile, but only while the external enable is high. In open capture, any hit opens a tile with no gating. A hit tile begins a programmable number of pre-hit samples before the hit. A later hit that arrives while the tile is still open lengthens it, up to a programmable limit.

Completed descriptors enter an event FIFO that the host drains. Full-drift capture accepts at most two overlapping windows. A capture start that cannot be kept, whether from pile-up or from lack of FIFO room, is dropped and counted.

Top module: `tile_builder`

## Requirements
- R1: Each frame with `s_valid` high advances the time tag by one and is written at ring address `tag mod RING_DEPTH`. Its content appears on `buf_rdata` one clock after `buf_raddr` selects that address.
- R2: In mode 2 (open), a frame with any hit bit set, while no tile is open, opens a tile of TILE_LEN samples whose first sample has tag `hit_tag - pre_len`.
- R3: In mode 1 (gated), a hit opens a tile exactly as in R2, but only when `ext_en` is high. Hits with `ext_en` low produce no fragment.
- R4: In mode 0 (full drift), `ext_trig` on a valid frame opens a window of DRIFT_LEN samples starting at that frame's tag. Hits and `pre_len` have no effect in this mode.
- R5: In the hit modes, a hit on a frame inside an open tile adds TILE_LEN samples to the tile. The total length is capped at `ext_max`.
- R6: A fragment record is queued on the last sample of its window and is visible the following cycle. Its fields are `frag_mode` (the mode at opening), `frag_tag` and `frag_len`. `frag_valid` falls only after a `frag_pop`, and records leave in completion order.
- R7: In mode 0, two windows may be open at once. `dead` is high while both are open, and a third trigger in that state is dropped and adds one to `rej_count`.
- R8: `busy` is high when the FIFO holds FRAG_DEPTH records. A capture start is dropped and counted when the free FIFO entries do not exceed the number of open windows, so the FIFO never overflows. `rej_count` saturates.
- R9: After reset, `frag_valid`, `busy` and `dead` are low and `rej_count` is zero.
- R10: Mode 3 (idle) opens nothing, whatever the hits and the trigger do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 full drift, 1 gated, 2 open, 3 idle |
| pre_len | input | PRE_W | Pre-hit samples for hit tiles |
| ext_max | input | 16 | Length cap for extended hit tiles |
| s_valid | input | 1 | Frame strobe |
| s_data | input | NCH*SW | Channel samples, channel c at bits [c*SW +: SW] |
| s_hit | input | NCH | Per-channel hit flags |
| ext_trig | input | 1 | External trigger |
| ext_en | input | 1 | External enable for gated mode |
| frag_pop | input | 1 | Removes the head record |
| frag_valid | output | 1 | FIFO holds a record |
| frag_mode | output | 2 | Head record mode code |
| frag_tag | output | 32 | Head record first-sample tag |
| frag_len | output | 16 | Head record sample count |
| busy | output | 1 | FIFO full |
| dead | output | 1 | Both full-drift windows open |
| rej_count | output | 16 | Dropped capture starts, saturating |
| buf_raddr | input | RAW | Ring read address |
| buf_rdata | output | NCH*SW | Ring read data, one cycle later |

## Verification
The bound checker watches, on every cycle, that the time tag steps only with valid frames and that no record is queued unless a window is open. It also checks that the FIFO is never written while full, that `dead` appears only with both windows open, that the reject count moves by at most one, and that `frag_valid` falls only after a pop. Fragment contents cannot be shown by those properties: the start tag after the pre-hit offset, the tile length, growth and its cap, gating by the enable, the insensitivity of full-drift mode to hits, and the order of piled-up windows. The bench scenarios cover them, together with the busy-driven rejection and the ring read-back.

// File: rtl/tile_pkg.sv
package tile_pkg;
   localparam int LEN_W = 16;
   localparam int TAG_W = 32;

   typedef enum logic [1:0] {
      MODE_DRIFT = 2'd0,
      MODE_GATED = 2'd1,
      MODE_OPEN  = 2'd2,
      MODE_IDLE  = 2'd3
   } cap_mode_e;

   typedef struct packed {
      logic [1:0]       mode;
      logic [TAG_W-1:0] tag;
      logic [LEN_W-1:0] len;
   } frag_rec_t;
endpackage

// File: rtl/tile_ring.sv
module tile_ring #(
   parameter int DEPTH = 128,
   parameter int DW    = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/tile_window.sv
module tile_window
   import tile_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             open_i,
   input  logic [1:0]       open_mode,
   input  logic [TAG_W-1:0] open_tag,
   input  logic [LEN_W-1:0] open_len,
   input  logic [LEN_W-1:0] open_rem,
   input  logic             ext_i,
   input  logic [LEN_W-1:0] ext_len,
   input  logic [LEN_W-1:0] ext_max,
   output logic             active_o,
   output logic             done_o,
   output frag_rec_t        rec_o
);
   logic             act;
   logic [LEN_W-1:0] rem, len;
   logic [TAG_W-1:0] tag;
   logic [1:0]       md;
   logic [LEN_W-1:0] room, add;
   logic             grow;

   always_comb begin
      room   = (ext_max > len) ? ext_max - len : '0;
      add    = (ext_len < room) ? ext_len : room;
      grow   = act && adv && ext_i && (add != '0);
      done_o = act && adv && (rem == LEN_W'(1)) && !grow;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act <= 1'b0;
         rem <= '0;
         len <= '0;
         tag <= '0;
         md  <= '0;
      end else if (adv) begin
         if (!act && open_i) begin
            act <= 1'b1;
            md  <= open_mode;
            tag <= open_tag;
            len <= open_len;
            rem <= open_rem;
         end else if (grow) begin
            len <= len + add;
            rem <= rem + add - LEN_W'(1);
         end else if (act) begin
            rem <= rem - LEN_W'(1);
            if (done_o) act <= 1'b0;
         end
      end
   end

   assign active_o = act;
   assign rec_o    = '{mode: md, tag: tag, len: len};
endmodule

// File: rtl/tile_fifo.sv
module tile_fifo #(
   parameter int DEPTH = 128,
   parameter int W     = 50,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          valid,
   output logic          full,
   output logic [CW-1:0] level
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign valid   = (level != '0);
   assign full    = (level == CW'(DEPTH));
   assign do_pop  = pop && valid;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         level <= level + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/tile_builder.sv
module tile_builder
   import tile_pkg::*;
#(
   parameter int NCH        = 16,
   parameter int SW         = 16,
   parameter int RING_DEPTH = 128,
   parameter int FRAG_DEPTH = 128,
   parameter int TILE_LEN   = 64,
   parameter int DRIFT_LEN  = 3750,
   parameter int PRE_W      = 5,
   parameter int RAW        = $clog2(RING_DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic [PRE_W-1:0]    pre_len,
   input  logic [15:0]         ext_max,
   input  logic                s_valid,
   input  logic [NCH*SW-1:0]   s_data,
   input  logic [NCH-1:0]      s_hit,
   input  logic                ext_trig,
   input  logic                ext_en,
   input  logic                frag_pop,
   output logic                frag_valid,
   output logic [1:0]          frag_mode,
   output logic [31:0]         frag_tag,
   output logic [15:0]         frag_len,
   output logic                busy,
   output logic                dead,
   output logic [15:0]         rej_count,
   input  logic [RAW-1:0]      buf_raddr,
   output logic [NCH*SW-1:0]   buf_rdata
);
   localparam int DW    = NCH * SW;
   localparam int NWIN  = 2;
   localparam int FCW   = $clog2(FRAG_DEPTH) + 1;
   localparam int REC_W = $bits(frag_rec_t);

   if (RING_DEPTH != (1 << RAW)) begin : g_bad_ring
      $error("RING_DEPTH must be a power of two");
   end
   if (FRAG_DEPTH != (1 << $clog2(FRAG_DEPTH))) begin : g_bad_fifo
      $error("FRAG_DEPTH must be a power of two");
   end
   if (RING_DEPTH < TILE_LEN + (1 << PRE_W)) begin : g_bad_pre
      $error("ring too shallow for pre-hit samples plus one tile");
   end
   if (TILE_LEN <= (1 << PRE_W) || DRIFT_LEN < 2) begin : g_bad_len
      $error("window lengths too short");
   end

   cap_mode_e        md;
   logic [TAG_W-1:0] tag_q;
   logic             any_hit, want_hit, want_trig, start_req, room_ok, accept;
   logic [NWIN-1:0]  w_open, w_ext, w_act, w_done;
   frag_rec_t        w_rec [NWIN];
   logic [TAG_W-1:0] o_tag;
   logic [LEN_W-1:0] o_len, o_rem;
   logic [1:0]       n_act;
   logic             frag_push;
   frag_rec_t        push_rec, head_rec;
   logic [REC_W-1:0] head_bits;
   logic [FCW-1:0]   f_level;

   assign md        = cap_mode_e'(mode);
   assign any_hit   = |s_hit;
   assign want_hit  = (md == MODE_OPEN && any_hit) ||
                      (md == MODE_GATED && any_hit && ext_en);
   assign want_trig = (md == MODE_DRIFT) && ext_trig;
   assign start_req = s_valid && (want_trig || (want_hit && !w_act[0]));
   assign n_act     = 2'(w_act[0]) + 2'(w_act[1]);
   assign room_ok   = (FCW'(FRAG_DEPTH) - f_level) > FCW'(n_act);
   assign accept    = start_req && room_ok && !(want_trig && (&w_act));

   assign w_open[0] = accept && !w_act[0];
   assign w_open[1] = accept && w_act[0] && want_trig;
   assign w_ext[0]  = want_hit && w_act[0];
   assign w_ext[1]  = 1'b0;

   always_comb begin
      if (want_trig) begin
         o_tag = tag_q;
         o_len = LEN_W'(DRIFT_LEN);
         o_rem = LEN_W'(DRIFT_LEN - 1);
      end else begin
         o_tag = tag_q - TAG_W'(pre_len);
         o_len = LEN_W'(TILE_LEN);
         o_rem = LEN_W'(TILE_LEN - 1) - LEN_W'(pre_len);
      end
   end

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      tile_window u_win (
         .clk       (clk),
         .rst_n     (rst_n),
         .adv       (s_valid),
         .open_i    (w_open[i]),
         .open_mode (mode),
         .open_tag  (o_tag),
         .open_len  (o_len),
         .open_rem  (o_rem),
         .ext_i     (w_ext[i]),
         .ext_len   (LEN_W'(TILE_LEN)),
         .ext_max   (ext_max),
         .active_o  (w_act[i]),
         .done_o    (w_done[i]),
         .rec_o     (w_rec[i])
      );
   end

   assign frag_push = |w_done;
   assign push_rec  = w_done[0] ? w_rec[0] : w_rec[1];

   tile_fifo #(.DEPTH(FRAG_DEPTH), .W(REC_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (frag_push),
      .din   (push_rec),
      .pop   (frag_pop),
      .dout  (head_bits),
      .valid (frag_valid),
      .full  (busy),
      .level (f_level)
   );

   assign head_rec  = frag_rec_t'(head_bits);
   assign frag_mode = head_rec.mode;
   assign frag_tag  = head_rec.tag;
   assign frag_len  = head_rec.len;
   assign dead      = (md == MODE_DRIFT) && (&w_act);

   tile_ring #(.DEPTH(RING_DEPTH), .DW(DW)) u_ring (
      .clk   (clk),
      .we    (s_valid),
      .waddr (tag_q[RAW-1:0]),
      .wdata (s_data),
      .raddr (buf_raddr),
      .rdata (buf_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q     <= '0;
         rej_count <= '0;
      end else begin
         if (s_valid) tag_q <= tag_q + TAG_W'(1);
         if (start_req && !accept && rej_count != 16'hFFFF)
            rej_count <= rej_count + 16'd1;
      end
   end
endmodule

// File: rtl/tile_builder_chk.sv
module tile_builder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        s_valid,
   input logic [31:0] tag,
   input logic        frag_valid,
   input logic        frag_pop,
   input logic        push,
   input logic        busy,
   input logic        dead,
   input logic [1:0]  w_act,
   input logic [15:0] rej_count
);
   a_r1_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |=> tag == $past(tag) + 32'd1);

   a_r1_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> $stable(tag));

   a_r6_push_from_window: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (w_act != 2'b00));

   a_r6_fall_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frag_valid) |-> $past(frag_pop));

   a_r7_dead_two_open: assert property (@(posedge clk) disable iff (!rst_n)
      dead |-> (w_act == 2'b11));

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && busy));

   a_r8_rej_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_count == $past(rej_count)) || (rej_count == $past(rej_count) + 16'd1));
endmodule

bind tile_builder tile_builder_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s_valid    (s_valid),
   .tag        (tag_q),
   .frag_valid (frag_valid),
   .frag_pop   (frag_pop),
   .push       (frag_push),
   .busy       (busy),
   .dead       (dead),
   .w_act      (w_act),
   .rej_count  (rej_count)
);

// File: tb/test_tile_builder.sv
module test_tile_builder;
   localparam int NCH = 16, SW = 16, RD = 16, FD = 4, TL = 8, DL = 12, PW = 2;
   localparam int RAW = $clog2(RD);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode = 2'd3;
   logic [PW-1:0]     pre_len = '0;
   logic [15:0]       ext_max = 16'd40;
   logic              s_valid = 1'b1;
   logic [NCH*SW-1:0] s_data;
   logic [NCH-1:0]    s_hit = '0;
   logic              ext_trig = 1'b0, ext_en = 1'b0, frag_pop = 1'b0;
   logic              frag_valid, busy, dead;
   logic [1:0]        frag_mode;
   logic [31:0]       frag_tag;
   logic [15:0]       frag_len, rej_count;
   logic [RAW-1:0]    buf_raddr = '0;
   logic [NCH*SW-1:0] buf_rdata;

   int checks = 0, errors = 0;
   logic [31:0] cnt;
   logic [15:0] exp_rej = 16'd0;

   always #10 clk = ~clk;

   always_ff @(posedge clk)
      if (!rst_n) cnt <= '0;
      else if (s_valid) cnt <= cnt + 32'd1;

   for (genvar c = 0; c < NCH; c++) begin : g_data
      assign s_data[c*SW +: SW] = {cnt[11:0], 4'(c)};
   end

   tile_builder #(.NCH(NCH), .SW(SW), .RING_DEPTH(RD), .FRAG_DEPTH(FD),
                  .TILE_LEN(TL), .DRIFT_LEN(DL), .PRE_W(PW)) i_tile_builder (
      .clk(clk), .rst_n(rst_n), .mode(mode), .pre_len(pre_len), .ext_max(ext_max),
      .s_valid(s_valid), .s_data(s_data), .s_hit(s_hit), .ext_trig(ext_trig),
      .ext_en(ext_en), .frag_pop(frag_pop), .frag_valid(frag_valid),
      .frag_mode(frag_mode), .frag_tag(frag_tag), .frag_len(frag_len),
      .busy(busy), .dead(dead), .rej_count(rej_count),
      .buf_raddr(buf_raddr), .buf_rdata(buf_rdata));

   // row: {mode[13:12], pre[11:10], en[9], made[8], len[7:0]}
   localparam logic [13:0] VEC [5] = '{
      {2'd2, 2'd2, 1'b0, 1'b1, 8'd8},   // R2 open, pre 2
      {2'd1, 2'd1, 1'b1, 1'b1, 8'd8},   // R3 gated, enable high
      {2'd1, 2'd0, 1'b0, 1'b0, 8'd0},   // R3 gated, enable low
      {2'd0, 2'd3, 1'b0, 1'b1, 8'd12},  // R4 drift, pre ignored
      {2'd3, 2'd0, 1'b1, 1'b0, 8'd0}    // R10 idle
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pop_one();
      frag_pop = 1'b1;
      nclk(1);
      frag_pop = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] tg;
      nclk(3);
      // R9 reset state
      chk("R9 frag_valid", 64'(frag_valid), 64'd0);
      chk("R9 busy", 64'(busy), 64'd0);
      chk("R9 dead", 64'(dead), 64'd0);
      chk("R9 rej_count", 64'(rej_count), 64'd0);
      rst_n = 1'b1;
      nclk(6);

      // R1 ring read-back
      tg = cnt - 32'd2;
      buf_raddr = tg[RAW-1:0];
      nclk(1);
      chk("R1 ring data", 64'(buf_rdata[5*SW +: SW]), 64'({tg[11:0], 4'd5}));

      // vector table
      for (int i = 0; i < 5; i++) begin
         logic [13:0] v;
         v = VEC[i];
         mode = v[13:12];
         pre_len = v[11:10];
         ext_en = v[9];
         tg = cnt;
         s_hit = 16'h0100;
         ext_trig = (v[13:12] != 2'd1 && v[13:12] != 2'd2);
         nclk(1);
         s_hit = '0;
         ext_trig = 1'b0;
         nclk(30);
         chk($sformatf("R6 row %0d made", i), 64'(frag_valid), 64'(v[8]));
         if (v[8]) begin
            chk($sformatf("R6 row %0d mode", i), 64'(frag_mode), 64'(v[13:12]));
            chk($sformatf("R2 R3 R4 row %0d tag", i), 64'(frag_tag),
                64'((v[13:12] == 2'd0) ? tg : tg - 32'(v[11:10])));
            chk($sformatf("R2 R3 R4 row %0d len", i), 64'(frag_len), 64'(v[7:0]));
            pop_one();
         end
         chk($sformatf("R6 row %0d drained", i), 64'(frag_valid), 64'd0);
      end

      // R5 extension, then capped
      mode = 2'd2;
      pre_len = '0;
      for (int k = 0; k < 2; k++) begin
         ext_max = (k == 0) ? 16'd40 : 16'd10;
         tg = cnt;
         s_hit = 16'h0001; nclk(1);
         s_hit = '0;       nclk(2);
         s_hit = 16'h8000; nclk(1);
         s_hit = '0;       nclk(30);
         chk("R5 ext tag", 64'(frag_tag), 64'(tg));
         chk("R5 ext len", 64'(frag_len), (k == 0) ? 64'd16 : 64'd10);
         pop_one();
      end
      ext_max = 16'd40;

      // R7 pile-up in drift mode
      mode = 2'd0;
      tg = cnt;
      ext_trig = 1'b1; nclk(1);
      ext_trig = 1'b0; nclk(1);
      ext_trig = 1'b1; nclk(1);
      ext_trig = 1'b0;
      chk("R7 dead with two open", 64'(dead), 64'd1);
      nclk(1);
      ext_trig = 1'b1; nclk(1);
      ext_trig = 1'b0;
      exp_rej = exp_rej + 16'd1;
      chk("R7 third trigger counted", 64'(rej_count), 64'(exp_rej));
      nclk(30);
      chk("R7 dead cleared", 64'(dead), 64'd0);
      chk("R7 first tag", 64'(frag_tag), 64'(tg));
      chk("R7 first len", 64'(frag_len), 64'd12);
      pop_one();
      chk("R7 second tag", 64'(frag_tag), 64'(tg + 32'd2));
      pop_one();
      chk("R7 only two", 64'(frag_valid), 64'd0);

      // R8 busy and rejection on a full FIFO
      mode = 2'd2;
      for (int k = 0; k < FD; k++) begin
         s_hit = 16'h0010; nclk(1);
         s_hit = '0;       nclk(12);
      end
      chk("R8 busy when full", 64'(busy), 64'd1);
      s_hit = 16'h0010; nclk(1);
      s_hit = '0;       nclk(12);
      exp_rej = exp_rej + 16'd1;
      chk("R8 start rejected", 64'(rej_count), 64'(exp_rej));
      for (int k = 0; k < FD; k++) begin
         chk("R8 stored record", 64'(frag_valid), 64'd1);
         pop_one();
      end
      chk("R8 nothing extra", 64'(frag_valid), 64'd0);
      chk("R8 busy cleared", 64'(busy), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule